// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is the compare-match timer that sits beside a processor core. A 32-bit Count register advances once every PRESCALE core clocks and wraps at 2^32. Software loads a 32-bit Compare value. When Count steps onto that value, the block raises a level interrupt on one of eight request lines. A small control register picks the line and can freeze the counter.

Software reaches Count, Compare, the control register and a status word through a one-cycle write port and a combinational read port. The only way to acknowledge the interrupt is to write Compare. A mode strap, `rev2_mode`, enables a pending flag that the status word exposes and that is set together with the interrupt.

Top module: `tick_match_timer`

## Requirements
- R1: Count increases by one every PRESCALE clocks while counting is enabled, and it wraps from 0xFFFFFFFF to 0x00000000.
- R2: The interrupt is raised when a prescaler tick moves Count onto the Compare value. It stays high until Compare is written or reset is applied.
- R3: Select 2 is the control register. Bits 3:1 of it are the routing field, and the interrupt appears only on `irq_lines[route]`. At most one line is ever high.
- R4: When `rev2_mode` is 1, a match also sets the pending flag. When it is 0, a match leaves the flag at 0.
- R5: A write to Compare (select 1) clears the interrupt and the pending flag on the next cycle, whatever value is written.
- R6: While control bit 0 (freeze) is 1, Count keeps its value, no interrupt can fire, and reads of Count return the held value.
- R7: A write to Count (select 0) loads the written value on the next cycle and restarts the prescaler from zero.
- R8: Clearing freeze resumes counting from the held Count and the held prescaler phase, with no tick lost or added.
- R9: Writing Compare with a value equal to the current Count does not raise the interrupt. A match needs a tick.
- R10: When a Count write and a tick fall on the same clock, the written value wins and that tick is dropped.
- R11: Reset sets Count, Compare, freeze, routing, the pending flag and all interrupt lines to 0.
- R12: Reads are combinational: select 0 gives Count, select 1 gives Compare, select 2 gives control, and select 3 gives the pending flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev2_mode | input | 1 | Enables the pending flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data |
| irq_lines | output | 8 | Interrupt request lines |
| pend | output | 1 | Pending flag |

## Verification
The collision of interest is a software Count write landing on the same clock as a prescaler tick. The bench places the second write exactly on the tick edge by counting clocks from an earlier Count write. It then expects the written value with no increment, followed by three clocks with no change and the next increment on the fourth. A second collision, a freeze write against the held prescaler phase, is judged by the clock on which the first increment and the interrupt appear after unfreezing.

// File: rtl/tick_match_timer.sv
module tick_match_timer #(
  parameter int PRESCALE = 4,
  parameter int WIDTH    = 32,
  parameter int IRQS     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rev2_mode,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic [IRQS-1:0]  irq_lines,
  output logic             pend
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int RW = (IRQS > 1) ? $clog2(IRQS) : 1;

  logic [WIDTH-1:0] count_q, compare_q;
  logic [PW-1:0]    pre_q;
  logic [RW-1:0]    route_q;
  logic             freeze_q, fired_q, pend_q;

  wire wr_cnt = wr_en && (wr_sel == 2'd0);
  wire wr_cmp = wr_en && (wr_sel == 2'd1);
  wire wr_ctl = wr_en && (wr_sel == 2'd2);

  wire             tick    = !freeze_q && (pre_q == PW'(PRESCALE - 1));
  wire [WIDTH-1:0] cnt_inc = count_q + 1'b1;
  wire             hit     = tick && !wr_cnt && (cnt_inc == compare_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      compare_q <= '0;
      pre_q     <= '0;
      route_q   <= '0;
      freeze_q  <= 1'b0;
      fired_q   <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (wr_cnt) begin
        count_q <= wr_data;
        pre_q   <= '0;
      end else if (tick) begin
        count_q <= cnt_inc;
        pre_q   <= '0;
      end else if (!freeze_q) begin
        pre_q <= pre_q + 1'b1;
      end

      if (wr_cmp) compare_q <= wr_data;
      if (wr_ctl) {route_q, freeze_q} <= wr_data[RW:0];

      if (wr_cmp) begin
        fired_q <= 1'b0;
        pend_q  <= 1'b0;
      end else if (hit) begin
        fired_q <= 1'b1;
        if (rev2_mode) pend_q <= 1'b1;
      end
    end
  end

  assign irq_lines = fired_q ? (IRQS'(1) << route_q) : '0;
  assign pend      = pend_q;

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = count_q;
      2'd1:    rd_data = compare_q;
      2'd2:    rd_data = {{(WIDTH-RW-1){1'b0}}, route_q, freeze_q};
      default: rd_data = {{(WIDTH-1){1'b0}}, pend_q};
    endcase
  end
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int WIDTH = 32,
  parameter int IRQS  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rev2_mode,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [WIDTH-1:0] wr_data,
  input logic [IRQS-1:0]  irq_lines,
  input logic             pend,
  input logic [WIDTH-1:0] count_q,
  input logic             freeze_q
);
  wire cw = wr_en && (wr_sel == 2'd0);
  wire mw = wr_en && (wr_sel == 2'd1);

  assert_one_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  assert_irq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_lines) && !mw) |=> (|irq_lines));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mw |=> (irq_lines == '0 && !pend));

  assert_pend_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rev2_mode && !pend) |=> !pend);

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !cw) |=> $stable(count_q));

  assert_count_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (count_q == $past(wr_data)));
endmodule

bind tick_match_timer timer_chk #(.WIDTH(WIDTH), .IRQS(IRQS)) chk (
  .clk(clk), .rst_n(rst_n), .rev2_mode(rev2_mode), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .irq_lines(irq_lines), .pend(pend),
  .count_q(count_q), .freeze_q(freeze_q)
);

// File: tb/tick_match_timer_test.sv
module tick_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rev2_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [7:0]  irq_lines;
  logic        pend;

  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_match_timer #(.PRESCALE(4)) uut (
    .clk(clk), .rst_n(rst_n), .rev2_mode(rev2_mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_lines(irq_lines), .pend(pend)
  );

  // {compare, route, rev2}
  localparam logic [35:0] VEC [0:4] = '{
    {32'h0000_0040, 3'd0, 1'b0},
    {32'h1234_5678, 3'd3, 1'b1},
    {32'h0000_0001, 3'd7, 1'b1},
    {32'h8000_0000, 3'd5, 1'b0},
    {32'hFFFF_FFFF, 3'd2, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    wait_n(3);
    rd(2'd0, v); check("R11 count", v, 32'h0);
    rd(2'd1, v); check("R11 compare", v, 32'h0);
    rd(2'd2, v); check("R11 control", v, 32'h0);
    rd(2'd3, v); check("R11 pending", v, 32'h0);
    check("R11 irq", {24'h0, irq_lines}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) begin
      logic [31:0] cmp;
      logic [2:0]  rt;
      cmp = VEC[i][35:4];
      rt = VEC[i][3:1];
      rev2_mode = VEC[i][0];
      wr(2'd2, {28'h0, rt, 1'b0});
      wr(2'd1, cmp);
      wr(2'd0, cmp - 32'd2);
      rd(2'd2, v); check("R12 control read", v, {28'h0, rt, 1'b0});
      rd(2'd1, v); check("R12 compare read", v, cmp);
      wait_n(3);
      rd(2'd0, v); check("R1 before tick", v, cmp - 32'd2);
      wait_n(1);
      rd(2'd0, v); check("R1 first tick", v, cmp - 32'd1);
      wait_n(3);
      check("R2 no early irq", {24'h0, irq_lines}, 32'h0);
      wait_n(1);
      rd(2'd0, v); check("R1 wrap/advance", v, cmp);
      check("R3 routed line", {24'h0, irq_lines}, 32'h1 << rt);
      rd(2'd3, v); check("R4 pending", v, {31'h0, VEC[i][0]});
      wait_n(9);
      check("R2 irq held", {24'h0, irq_lines}, 32'h1 << rt);
      wr(2'd1, cmp + 32'd77);
      check("R5 irq cleared", {24'h0, irq_lines}, 32'h0);
      rd(2'd3, v); check("R5 pending cleared", v, 32'h0);
    end

    // stale equality
    rev2_mode = 1'b1;
    wr(2'd2, 32'h0);
    wr(2'd0, 32'd100);
    wr(2'd1, 32'd100);
    wait_n(12);
    check("R9 no stale match", {24'h0, irq_lines}, 32'h0);
    rd(2'd0, v); check("R9 count moved", v, 32'd103);

    // freeze and resume
    wr(2'd0, 32'd50);
    wr(2'd1, 32'd52);
    wr(2'd2, 32'h1);
    wait_n(40);
    rd(2'd0, v); check("R6 frozen count", v, 32'd50);
    check("R6 no irq frozen", {24'h0, irq_lines}, 32'h0);
    wr(2'd0, 32'd51);
    wait_n(20);
    rd(2'd0, v); check("R6 frozen after load", v, 32'd51);
    check("R6 no match while frozen", {24'h0, irq_lines}, 32'h0);
    wr(2'd0, 32'd50);
    wr(2'd2, 32'h0);
    // prescaler phase now 0; resumes at F
    wait_n(3);
    rd(2'd0, v); check("R8 no early tick", v, 32'd50);
    wait_n(1);
    rd(2'd0, v); check("R8 first tick", v, 32'd51);
    wait_n(3);
    check("R8 no early match", {24'h0, irq_lines}, 32'h0);
    wait_n(1);
    check("R8 match after resume", {24'h0, irq_lines}, 32'h1);
    wr(2'd1, 32'h0);

    // freeze with held phase: two clocks spent before freezing
    wr(2'd0, 32'd50);
    wr(2'd1, 32'd52);
    wr(2'd2, 32'h1);
    wait_n(30);
    wr(2'd2, 32'h0);
    wait_n(1);
    rd(2'd0, v); check("R8 phase held", v, 32'd50);
    wait_n(1);
    rd(2'd0, v); check("R8 phase resumed", v, 32'd51);
    wait_n(3);
    check("R8 phase no early irq", {24'h0, irq_lines}, 32'h0);
    wait_n(1);
    check("R8 phase irq", {24'h0, irq_lines}, 32'h1);
    wr(2'd1, 32'h0);

    // count write on a tick edge
    wr(2'd0, 32'h1000);
    wait_n(3);
    wr(2'd0, 32'h2000);
    rd(2'd0, v); check("R10 write wins", v, 32'h2000);
    wait_n(3);
    rd(2'd0, v); check("R7 prescaler restart", v, 32'h2000);
    wait_n(1);
    rd(2'd0, v); check("R7 next tick", v, 32'h2001);

    // rev2 off: pending stays clear
    rev2_mode = 1'b0;
    wr(2'd1, 32'h3000);
    wr(2'd0, 32'h2FFF);
    wait_n(4);
    check("R2 match rev2 off", {24'h0, irq_lines}, 32'h1);
    rd(2'd3, v); check("R4 no pending rev2 off", v, 32'h0);
    wr(2'd1, 32'h3000);
    check("R5 same value ack", {24'h0, irq_lines}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule